// File: doc/BRIEF.md
# Parallel Link Source Transmitter

This block is the sending end of a 32-bit parallel front-panel link. A local valid/ready stream supplies words, each with a start-of-frame flag. The block places every accepted word on the link data bus for one cycle and drives an active-low valid strobe with it. It holds the direction line low and issues a one-cycle active-low sync pulse ahead of the first word of each frame. All link outputs are registered on the block clock. That clock is the free-running strobe that travels with the data, and the receiver captures on its rising edge.

The receiver throttles the source through two asynchronous active-low inputs. Not-ready holds off transfers, and suspend warns of a pending overflow at the far end. Each input passes through its own two-flop synchronizer. While either one is in force, the local stream sees ready low, so no word is dropped or sent twice. After suspend is asserted, the link stops within three clock edges, which is well inside the sixteen-cycle allowance the link grants. Sending resumes once the release of suspend has been synchronized.

Top module: `fpl_src_tx`

## Requirements
- R1: While rst_ni is low: link_dvalid_no=1, link_sync_no=1, link_dir_no=0 and in_ready_o=0.
- R2: link_dir_no is 0 at all times.
- R3: A word is accepted at a rising edge where in_valid_i=1 and in_ready_o=1. It appears on link_data_o with link_dvalid_no=0 for exactly the next cycle. In every cycle without an acceptance, link_dvalid_no=1.
- R4: After reset, in_ready_o stays 0 and no word is sent while link_nrdy_ni=0. When link_nrdy_ni rises before edge E0, in_ready_o is 1 after edge E1, and a pending word is on the bus after edge E2.
- R5: When link_susp_ni falls before edge E0, in_ready_o is 0 after edge E1. link_dvalid_no is 1 from edge E2 on, and it stays 1 while suspend is held.
- R6: When link_susp_ni rises before edge E0, in_ready_o returns to 1 after edge E1, and the next word is on the bus after edge E2.
- R7: Take a word with in_sof_i=1 that is presented while the link is open. In the first cycle, in_ready_o=0 and link_sync_no pulses low for one cycle while link_dvalid_no=1. The word is accepted at the next edge and goes out in the cycle right after the pulse.
- R8: If the link closes between the sync pulse and the acceptance of its start-of-frame word, the pulse is void. A fresh pulse is issued just before the word once the link reopens.
- R9: Words with in_sof_i=0 never produce a sync pulse. Back-to-back frames each get their own pulse.
- R10: Across a suspend and its release, the words on the bus are exactly the accepted words, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running strobe clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Local word valid |
| in_sof_i | input | 1 | Local word starts a frame |
| in_data_i | input | 32 | Local word |
| in_ready_o | output | 1 | Local word accepted at next edge when valid |
| link_data_o | output | 32 | Link data bus |
| link_dvalid_no | output | 1 | Link data valid, active low |
| link_dir_no | output | 1 | Link direction, held low |
| link_sync_no | output | 1 | Frame sync pulse, active low |
| link_nrdy_ni | input | 1 | Receiver not ready, asynchronous, active low |
| link_susp_ni | input | 1 | Receiver suspend request, asynchronous, active low |

## Verification
A change on either flow-control input reaches in_ready_o after two edges and link_dvalid_no after three. A local acceptance shows on the bus one edge later. A sync pulse precedes its word by exactly one cycle. The bench drives inputs on the falling edge and reads registered outputs at the next falling edge. It counts edges from each input change to place every check on the exact cycle it predicts. It reads in_ready_o one time unit after driving, before the edge that uses it.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned SYNC_STAGES = 2;
  // edges from suspend/not-ready falling to link idle
  localparam int unsigned STOP_LAT    = SYNC_STAGES + 1;
  localparam int unsigned STOP_LIMIT  = 16;
endpackage

// File: rtl/fpl_sync.sv
module fpl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fpl_gate.sv
module fpl_gate #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrdy_ni,
  input  logic susp_ni,
  output logic open_o
);
  localparam int unsigned N_IN = 2;

  logic [N_IN-1:0] raw_n, sync_n;
  assign raw_n = {susp_ni, nrdy_ni};

  // both inputs reset to "asserted" so the link starts closed
  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    fpl_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_n[i]),
      .q_o   (sync_n[i])
    );
  end

  assign open_o = &sync_n;
endmodule

// File: rtl/fpl_frame.sv
module fpl_frame (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic in_sof_i,
  input  logic open_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic sync_fire_o
);
  logic armed_q;

  assign sync_fire_o = open_i & in_valid_i & in_sof_i & ~armed_q;
  assign in_ready_o  = open_i & (~in_sof_i | armed_q);
  assign accept_o    = in_valid_i & in_ready_o;

  // a pulse only counts if its word follows on the very next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_q <= 1'b0;
    else if (sync_fire_o)         armed_q <= 1'b1;
    else if (!open_i || accept_o) armed_q <= 1'b0;
  end

  // R7
  sync_holds_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_fire_o |-> !accept_o);

  // R8
  closed_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |-> (!accept_o && !sync_fire_o));
endmodule

// File: rtl/fpl_out.sv
module fpl_out #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          sync_fire_i,
  input  logic          sof_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          dvalid_no,
  output logic          sync_no,
  output logic          dir_no
);
  logic sof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      dvalid_no <= 1'b1;
      sync_no   <= 1'b1;
      sof_q     <= 1'b0;
    end else begin
      dvalid_no <= ~accept_i;
      sync_no   <= ~sync_fire_i;
      if (accept_i) begin
        data_o <= data_i;
        sof_q  <= sof_i;
      end
    end
  end

  assign dir_no = 1'b0;

  // R7
  sync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_no |-> dvalid_no);

  // R7
  sof_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dvalid_no && sof_q) |-> $past(!sync_no));
endmodule

// File: rtl/fpl_src_tx.sv
module fpl_src_tx
  import fpl_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_sof_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic [DW-1:0] link_data_o,
  output logic          link_dvalid_no,
  output logic          link_dir_no,
  output logic          link_sync_no,
  input  logic          link_nrdy_ni,
  input  logic          link_susp_ni
);
  localparam int unsigned CNT_W = $clog2(STOP_LAT + 1);

  logic open, accept, sync_fire;

  fpl_gate #(.STAGES(SYNC_STAGES)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nrdy_ni(link_nrdy_ni),
    .susp_ni(link_susp_ni),
    .open_o (open)
  );

  fpl_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_sof_i   (in_sof_i),
    .open_i     (open),
    .in_ready_o (in_ready_o),
    .accept_o   (accept),
    .sync_fire_o(sync_fire)
  );

  fpl_out #(.DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .sync_fire_i(sync_fire),
    .sof_i      (in_sof_i),
    .data_i     (in_data_i),
    .data_o     (link_data_o),
    .dvalid_no  (link_dvalid_no),
    .sync_no    (link_sync_no),
    .dir_no     (link_dir_no)
  );

  // edges seen with each raw flow-control input low, saturating
  logic [CNT_W-1:0] susp_cnt_q, nrdy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_cnt_q <= '0;
      nrdy_cnt_q <= '0;
    end else begin
      if (link_susp_ni)                          susp_cnt_q <= '0;
      else if (susp_cnt_q != CNT_W'(STOP_LAT))   susp_cnt_q <= susp_cnt_q + 1'b1;
      if (link_nrdy_ni)                          nrdy_cnt_q <= '0;
      else if (nrdy_cnt_q != CNT_W'(STOP_LAT))   nrdy_cnt_q <= nrdy_cnt_q + 1'b1;
    end
  end

  initial begin
    // R5
    stop_bound_chk: assert (STOP_LAT <= STOP_LIMIT);
  end

  // R5
  susp_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_cnt_q == CNT_W'(STOP_LAT)) |-> link_dvalid_no);

  // R4
  nrdy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrdy_cnt_q == CNT_W'(STOP_LAT)) |-> (link_dvalid_no && !in_ready_o));

  // R3
  word_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!link_dvalid_no && link_data_o == $past(in_data_i)));

  // R2
  dir_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_dir_no);
endmodule

// File: tb/fpl_src_tx_bench.sv
module fpl_src_tx_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_sof_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o;
  logic [31:0] link_data_o;
  logic        link_dvalid_no, link_dir_no, link_sync_no;
  logic        link_nrdy_ni = 1'b0;
  logic        link_susp_ni = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fpl_src_tx u_fpl_src_tx (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid_i),
    .in_sof_i      (in_sof_i),
    .in_data_i     (in_data_i),
    .in_ready_o    (in_ready_o),
    .link_data_o   (link_data_o),
    .link_dvalid_no(link_dvalid_no),
    .link_dir_no   (link_dir_no),
    .link_sync_no  (link_sync_no),
    .link_nrdy_ni  (link_nrdy_ni),
    .link_susp_ni  (link_susp_ni)
  );

  typedef struct packed {
    logic        valid;
    logic        sof;
    logic [31:0] data;
    logic        exp_rdy;
    logic        exp_dvn;
    logic        exp_syn;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'h0,        1'b1, 1'b1, 1'b1}, // R3 idle
    '{1'b1, 1'b1, 32'hA1A1A1A1, 1'b0, 1'b1, 1'b0}, // R7 pulse
    '{1'b1, 1'b1, 32'hA1A1A1A1, 1'b1, 1'b0, 1'b1}, // R7 word
    '{1'b1, 1'b0, 32'hA2A2A2A2, 1'b1, 1'b0, 1'b1}, // R9
    '{1'b0, 1'b0, 32'h0,        1'b1, 1'b1, 1'b1}, // R3
    '{1'b1, 1'b0, 32'hA3A3A3A3, 1'b1, 1'b0, 1'b1}, // R9 no pulse
    '{1'b1, 1'b1, 32'hB1B1B1B1, 1'b0, 1'b1, 1'b0}, // R9
    '{1'b1, 1'b1, 32'hB1B1B1B1, 1'b1, 1'b0, 1'b1}, // R9
    '{1'b1, 1'b1, 32'hC1C1C1C1, 1'b0, 1'b1, 1'b0}, // R9 back to back
    '{1'b1, 1'b1, 32'hC1C1C1C1, 1'b1, 1'b0, 1'b1}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  logic        last_hs = 1'b0;
  logic        obs_dv, obs_rdy;
  logic [31:0] seq_exp;

  // one cycle of the streaming phase, R10 bus-order monitor included
  task automatic cyc(input logic susp_v);
    @(negedge clk);
    obs_dv  = link_dvalid_no;
    obs_rdy = in_ready_o;
    if (!obs_dv) begin
      chk("R10", link_data_o, seq_exp);
      seq_exp = seq_exp + 1;
    end
    if (last_hs) in_data_i = in_data_i + 1;
    link_susp_ni = susp_v;
    #1 last_hs = in_valid_i && in_ready_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    // reset, not-ready held
    in_valid_i = 1'b1;
    in_data_i  = 32'hA5;
    repeat (3) @(negedge clk);
    chk("R1 dvalid", 32'(link_dvalid_no), 32'd1);
    chk("R1 sync",   32'(link_sync_no),   32'd1);
    chk("R1 dir",    32'(link_dir_no),    32'd0);
    chk("R1 ready",  32'(in_ready_o),     32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 hold ready",  32'(in_ready_o),     32'd0);
      chk("R4 hold dvalid", 32'(link_dvalid_no), 32'd1);
    end
    link_nrdy_ni = 1'b1;          // before E0
    @(negedge clk);               // after E0
    chk("R4 ready E0", 32'(in_ready_o), 32'd0);
    @(negedge clk);               // after E1
    chk("R4 ready E1",  32'(in_ready_o),     32'd1);
    chk("R4 dvalid E1", 32'(link_dvalid_no), 32'd1);
    @(negedge clk);               // after E2
    chk("R4 dvalid E2", 32'(link_dvalid_no), 32'd0);
    chk("R4 data E2",   link_data_o,         32'hA5);
    chk("R2 dir",       32'(link_dir_no),    32'd0);

    // vector table, link open
    for (int i = 0; i < NV; i++) begin
      in_valid_i = VEC[i].valid;
      in_sof_i   = VEC[i].sof;
      in_data_i  = VEC[i].data;
      #1 chk($sformatf("R7/R9 ready v%0d", i), 32'(in_ready_o), 32'(VEC[i].exp_rdy));
      @(negedge clk);
      chk($sformatf("R3 dvalid v%0d", i), 32'(link_dvalid_no), 32'(VEC[i].exp_dvn));
      chk($sformatf("R7 sync v%0d", i),   32'(link_sync_no),   32'(VEC[i].exp_syn));
      if (!VEC[i].exp_dvn) chk($sformatf("R3 data v%0d", i), link_data_o, VEC[i].data);
    end

    // suspend during a stream
    in_valid_i = 1'b1;
    in_sof_i   = 1'b0;
    in_data_i  = 32'h100;
    seq_exp    = 32'h100;
    #1 last_hs = in_valid_i && in_ready_o;
    repeat (3) cyc(1'b1);
    cyc(1'b0);                    // drives before E0
    cyc(1'b0);
    chk("R5 dvalid E0", 32'(obs_dv), 32'd0);
    cyc(1'b0);
    chk("R5 dvalid E1", 32'(obs_dv),  32'd0);
    chk("R5 ready E1",  32'(obs_rdy), 32'd0);
    cyc(1'b0);
    chk("R5 dvalid E2", 32'(obs_dv), 32'd1);
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0);
      chk("R5 held dvalid", 32'(obs_dv),  32'd1);
      chk("R5 held ready",  32'(obs_rdy), 32'd0);
    end
    cyc(1'b1);                    // release before F0
    cyc(1'b1);
    chk("R6 ready F0", 32'(obs_rdy), 32'd0);
    cyc(1'b1);
    chk("R6 ready F1",  32'(obs_rdy), 32'd1);
    chk("R6 dvalid F1", 32'(obs_dv),  32'd1);
    cyc(1'b1);
    chk("R6 dvalid F2", 32'(obs_dv), 32'd0);
    repeat (4) cyc(1'b1);

    // sync pulse voided by a closing link
    @(negedge clk);
    in_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 idle", 32'(link_dvalid_no), 32'd1);
    link_susp_ni = 1'b0;          // before E0
    @(negedge clk);
    in_valid_i = 1'b1;
    in_sof_i   = 1'b1;
    in_data_i  = 32'hC0DE;
    @(negedge clk);               // after E1
    chk("R8 sync E1",   32'(link_sync_no),   32'd0);
    chk("R8 dvalid E1", 32'(link_dvalid_no), 32'd1);
    @(negedge clk);               // after E2
    chk("R8 sync E2",   32'(link_sync_no),   32'd1);
    chk("R8 dvalid E2", 32'(link_dvalid_no), 32'd1);
    chk("R8 ready E2",  32'(in_ready_o),     32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R8 closed dvalid", 32'(link_dvalid_no), 32'd1);
      chk("R8 closed sync",   32'(link_sync_no),   32'd1);
    end
    link_susp_ni = 1'b1;          // before F0
    @(negedge clk);
    chk("R8 sync F0", 32'(link_sync_no), 32'd1);
    @(negedge clk);
    chk("R8 sync F1",  32'(link_sync_no), 32'd1);
    chk("R8 ready F1", 32'(in_ready_o),   32'd0);
    @(negedge clk);
    chk("R8 sync F2",   32'(link_sync_no),   32'd0);
    chk("R8 dvalid F2", 32'(link_dvalid_no), 32'd1);
    @(negedge clk);
    chk("R8 dvalid F3", 32'(link_dvalid_no), 32'd0);
    chk("R8 data F3",   link_data_o,         32'hC0DE);
    chk("R8 sync F3",   32'(link_sync_no),   32'd1);
    in_valid_i = 1'b0;
    in_sof_i   = 1'b0;
    @(negedge clk);
    chk("R2 dir end", 32'(link_dir_no), 32'd0);

    summary();
    $finish;
  end
endmodule